// File: doc/BRIEF.md
# Virtual-Screen Frame Buffer Address Generator

This block produces the word fetch addresses that feed a display controller from a frame buffer. The visible picture is a viewport cut out of a wider virtual screen. Each visible line is read as a run of consecutive halfwords. The address then jumps forward by a skip offset to reach the first halfword of the next visible line. At frame start the walk reloads from a base address. The block computes where the frame ends, and it stops fetching once that address is reached.

Addresses are held in halfword units. They are split into a constant bank field and a lower field that wraps. Fetches are 32-bit words on a request/acknowledge port. Each returned word can have its halfwords exchanged, the bytes inside each halfword exchanged, or both, before it is presented downstream. A timing generator supplies a frame sync pulse to start a frame and a line sync pulse to release each line after the first.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, req_o, frame_done_o and data_valid_o are 0.
- R2: A frame_sync_i pulse with a valid configuration makes the next request address {3'b000, bank_i, base_i, 1'b0}, a byte address with the bank in bits 28:22 and the halfword base in bits 21:1.
- R3: Within a line, successive requests step by one 32-bit word (2 halfwords, 4 bytes), and a line holds page_width_i/2 requests.
- R4: After the last word of a line, the next line begins at last halfword + 2 + skip_i, and no request is issued until line_sync_i is pulsed.
- R5: While req_o is 1 and ack_i is 0, req_o stays 1 and addr_o stays unchanged.
- R6: end_addr_o equals (base_i + (page_width_i + skip_i) * (line_count_i + 1)) mod 2^21. When a line ends exactly at the end address latched at frame sync, frame_done_o pulses for one cycle and no request follows until the next frame_sync_i.
- R7: The 21-bit halfword field wraps from 0x1FFFFF to 0, and the bank bits of addr_o are unaffected by the wrap.
- R8: cfg_err_o is 1 when page_width_i is odd or zero. A frame_sync_i that arrives while cfg_err_o is 1 starts no fetches.
- R9: data_valid_o is 1 in the cycle after an accepted fetch (req_o and ack_i both 1), with data_o taken from rdata_i. swap_halves_i=1 exchanges bits 31:16 with bits 15:0. swap_bytes_i=1 then exchanges the two bytes inside each halfword. For 0x11223344 the results are 0x11223344, 0x33441122, 0x22114433 and 0x44332211 for none, halves, bytes and both.
- R10: A frame_sync_i during an active frame abandons that frame and restarts the walk from the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | 7 | Bank field, address bits 28:22 |
| base_i | input | 21 | Frame start, halfword units |
| page_width_i | input | 11 | Visible halfwords per line |
| skip_i | input | 11 | Halfwords skipped between lines |
| line_count_i | input | 10 | Number of lines minus one |
| swap_halves_i | input | 1 | Exchange the two halfwords of a fetched word |
| swap_bytes_i | input | 1 | Exchange the bytes inside each halfword |
| frame_sync_i | input | 1 | Frame start pulse |
| line_sync_i | input | 1 | Releases the next line |
| ack_i | input | 1 | Fetch accepted, rdata_i valid |
| rdata_i | input | 32 | Fetched word |
| req_o | output | 1 | Fetch request |
| addr_o | output | 32 | Fetch byte address |
| data_o | output | 32 | Swapped fetched word |
| data_valid_o | output | 1 | data_o valid |
| end_addr_o | output | 21 | Computed frame end, halfword units |
| frame_done_o | output | 1 | End reached, one-cycle pulse |
| cfg_err_o | output | 1 | Odd or zero page width |

## Verification
The walk is tried with a nonzero skip over two lines. The jump between lines only appears when the skip is added after the final word, so a missing or misplaced add is exposed. A one-line frame placed just below the top of the halfword space tells a correct 21-bit wrap apart from a carry into the bank bits. Delayed acknowledges separate a held request from one that advances on its own. Four words returned under the four swap settings separate halfword reordering from byte reordering. Odd and zero widths, a line held back by a missing line sync, and a mid-line frame restart cover the gating paths.

// File: rtl/fb_addr_pkg.sv
`timescale 1ns/1ps
package fb_addr_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fb_end_calc.sv
`timescale 1ns/1ps
module fb_end_calc #(
  parameter int unsigned HW_ADDR_W = 21,
  parameter int unsigned DIM_W     = 11,
  parameter int unsigned LINE_W    = 10
) (
  input  logic [HW_ADDR_W-1:0] base_i,
  input  logic [DIM_W-1:0]     page_width_i,
  input  logic [DIM_W-1:0]     skip_i,
  input  logic [LINE_W-1:0]    line_count_i,
  output logic [HW_ADDR_W-1:0] end_addr_o,
  output logic                 cfg_err_o
);
  localparam int unsigned SPAN_W = DIM_W + 1;
  localparam int unsigned ROWS_W = LINE_W + 1;
  localparam int unsigned PROD_W = SPAN_W + ROWS_W;

  logic [SPAN_W-1:0] span;
  logic [ROWS_W-1:0] rows;
  logic [PROD_W-1:0] prod;

  always_comb begin
    span       = {1'b0, page_width_i} + {1'b0, skip_i};
    rows       = {1'b0, line_count_i} + ROWS_W'(1);
    prod       = PROD_W'(span) * PROD_W'(rows);
    end_addr_o = base_i + HW_ADDR_W'(prod);
    // whole-word fetches need an even, nonzero width
    cfg_err_o  = page_width_i[0] | (page_width_i == '0);
  end
endmodule

// File: rtl/fb_fetch_seq.sv
`timescale 1ns/1ps
module fb_fetch_seq
  import fb_addr_pkg::*;
#(
  parameter int unsigned BANK_W    = 7,
  parameter int unsigned HW_ADDR_W = 21,
  parameter int unsigned DIM_W     = 11,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [HW_ADDR_W-1:0] base_i,
  input  logic [DIM_W-1:0]     page_width_i,
  input  logic [DIM_W-1:0]     skip_i,
  input  logic [HW_ADDR_W-1:0] end_addr_i,
  input  logic                 cfg_err_i,
  input  logic                 frame_sync_i,
  input  logic                 line_sync_i,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 frame_done_o
);
  localparam int unsigned CNT_W = DIM_W - 1;
  localparam int unsigned PAD_W = ADDR_W - BANK_W - HW_ADDR_W - 1;

  seq_state_e           state_q;
  logic [HW_ADDR_W-1:0] cur_q, end_q, line_next;
  logic [BANK_W-1:0]    bank_q;
  logic [CNT_W-1:0]     words_q, cnt_q;
  logic [DIM_W-1:0]     skip_q;
  logic                 done_q, last_word;

  assign last_word = (cnt_q == words_q - CNT_W'(1));
  assign line_next = cur_q + HW_ADDR_W'(2) + HW_ADDR_W'(skip_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      bank_q  <= '0;
      words_q <= '0;
      cnt_q   <= '0;
      skip_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_sync_i) begin
        state_q <= cfg_err_i ? S_IDLE : S_FETCH;
        cur_q   <= base_i;
        end_q   <= end_addr_i;
        bank_q  <= bank_i;
        words_q <= page_width_i[DIM_W-1:1];
        skip_q  <= skip_i;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          S_FETCH: if (ack_i) begin
            if (last_word) begin
              cur_q <= line_next;
              cnt_q <= '0;
              if (line_next == end_q) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= S_WAIT;
              end
            end else begin
              cur_q <= cur_q + HW_ADDR_W'(2);
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_WAIT: if (line_sync_i) state_q <= S_FETCH;
          default: ;
        endcase
      end
    end
  end

  assign req_o        = (state_q == S_FETCH);
  assign addr_o       = {{PAD_W{1'b0}}, bank_q, cur_q, 1'b0};
  assign frame_done_o = done_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && !frame_sync_i |=> req_o && $stable(addr_o));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  p_quiet_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !req_o);
  p_line_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) && !line_sync_i && !frame_sync_i |=> !req_o);
  p_err_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i && cfg_err_i |=> !req_o);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !last_word && !frame_sync_i |=>
      addr_o[HW_ADDR_W:1] == $past(addr_o[HW_ADDR_W:1]) + HW_ADDR_W'(2));
endmodule

// File: rtl/fb_word_swap.sv
`timescale 1ns/1ps
module fb_word_swap #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              swap_halves_i,
  input  logic              swap_bytes_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned LANES  = DATA_W / 16;

  logic [DATA_W-1:0] halved, swapped;

  assign halved = swap_halves_i ? {data_i[HALF_W-1:0], data_i[DATA_W-1:HALF_W]} : data_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign swapped[16*g +: 16] = swap_bytes_i ?
      {halved[16*g +: 8], halved[16*g+8 +: 8]} : halved[16*g +: 16];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take_i;
      if (take_i) data_o <= swapped;
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> valid_o);
  p_valid_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !valid_o);
endmodule

// File: rtl/fb_addr_gen.sv
`timescale 1ns/1ps
module fb_addr_gen #(
  parameter int unsigned BANK_W    = 7,
  parameter int unsigned HW_ADDR_W = 21,
  parameter int unsigned DIM_W     = 11,
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [HW_ADDR_W-1:0] base_i,
  input  logic [DIM_W-1:0]     page_width_i,
  input  logic [DIM_W-1:0]     skip_i,
  input  logic [LINE_W-1:0]    line_count_i,
  input  logic                 swap_halves_i,
  input  logic                 swap_bytes_i,
  input  logic                 frame_sync_i,
  input  logic                 line_sync_i,
  input  logic                 ack_i,
  input  logic [DATA_W-1:0]    rdata_i,
  output logic                 req_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_valid_o,
  output logic [HW_ADDR_W-1:0] end_addr_o,
  output logic                 frame_done_o,
  output logic                 cfg_err_o
);
  logic [HW_ADDR_W-1:0] end_addr;
  logic                 cfg_err, req, take;

  fb_end_calc #(.HW_ADDR_W(HW_ADDR_W), .DIM_W(DIM_W), .LINE_W(LINE_W)) i_end_calc (
    .base_i       (base_i),
    .page_width_i (page_width_i),
    .skip_i       (skip_i),
    .line_count_i (line_count_i),
    .end_addr_o   (end_addr),
    .cfg_err_o    (cfg_err)
  );

  fb_fetch_seq #(.BANK_W(BANK_W), .HW_ADDR_W(HW_ADDR_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bank_i       (bank_i),
    .base_i       (base_i),
    .page_width_i (page_width_i),
    .skip_i       (skip_i),
    .end_addr_i   (end_addr),
    .cfg_err_i    (cfg_err),
    .frame_sync_i (frame_sync_i),
    .line_sync_i  (line_sync_i),
    .ack_i        (ack_i),
    .req_o        (req),
    .addr_o       (addr_o),
    .frame_done_o (frame_done_o)
  );

  assign take = req & ack_i;

  fb_word_swap #(.DATA_W(DATA_W)) i_swap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .swap_halves_i (swap_halves_i),
    .swap_bytes_i  (swap_bytes_i),
    .data_i        (rdata_i),
    .data_o        (data_o),
    .valid_o       (data_valid_o)
  );

  assign req_o      = req;
  assign end_addr_o = end_addr;
  assign cfg_err_o  = cfg_err;
endmodule

// File: tb/test_fb_addr_gen.sv
`timescale 1ns/1ps
module test_fb_addr_gen;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  bank = '0;
  logic [20:0] base = '0;
  logic [10:0] pw = 11'd4, skip = '0;
  logic [9:0]  lines = '0;
  logic        sw_h = 0, sw_b = 0, fsync = 0, lsync = 0, ack = 0;
  logic [31:0] rdata = '0;
  logic        req, dvalid, done, err;
  logic [31:0] addr, dout;
  logic [20:0] end_addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fb_addr_gen i_fb_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .bank_i(bank), .base_i(base),
    .page_width_i(pw), .skip_i(skip), .line_count_i(lines),
    .swap_halves_i(sw_h), .swap_bytes_i(sw_b), .frame_sync_i(fsync),
    .line_sync_i(lsync), .ack_i(ack), .rdata_i(rdata), .req_o(req),
    .addr_o(addr), .data_o(dout), .data_valid_o(dvalid),
    .end_addr_o(end_addr), .frame_done_o(done), .cfg_err_o(err));

  function automatic logic [31:0] baddr(input logic [6:0] b, input logic [20:0] hw);
    return {3'b000, b, hw, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic start_frame();
    @(negedge clk) fsync = 1;
    @(negedge clk) fsync = 0;
  endtask

  // one word fetch: request must already be up at this negedge
  task automatic fetch(input logic [20:0] hw, input int hold, input logic [31:0] d, input logic [31:0] exp_d);
    chk(req === 1'b1, "R3 request present", 32'(req), 32'd1);
    chk(addr === baddr(bank, hw), "R2/R3 address", addr, baddr(bank, hw));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(req === 1'b1 && addr === baddr(bank, hw), "R5 held request", addr, baddr(bank, hw));
    end
    ack = 1; rdata = d;
    @(negedge clk) ack = 0;
    chk(dvalid === 1'b1 && dout === exp_d, "R9 data out", dout, exp_d);
  endtask

  task automatic t_reset();
    chk(req === 0 && done === 0 && dvalid === 0, "R1 reset state",
        {29'd0, req, done, dvalid}, 32'd0);
  endtask

  task automatic t_two_lines();
    bank = 7'h05; base = 21'h100; pw = 11'd4; skip = 11'd6; lines = 10'd1;
    #1 chk(end_addr === 21'h114, "R6 end address", 32'(end_addr), 32'h114);
    start_frame();
    fetch(21'h100, 0, 32'hA0A0A0A0, 32'hA0A0A0A0);
    fetch(21'h102, 0, 32'hA1A1A1A1, 32'hA1A1A1A1);
    chk(done === 0, "R6 no early done", 32'(done), 0);
    for (int i = 0; i < 4; i++) begin
      chk(req === 0, "R4 waits for line sync", 32'(req), 0);
      @(negedge clk);
    end
    lsync = 1;
    @(negedge clk) lsync = 0;
    fetch(21'h10A, 0, 32'h1, 32'h1);
    fetch(21'h10C, 0, 32'h2, 32'h2);
    chk(done === 1, "R6 done pulse", 32'(done), 1);
    @(negedge clk);
    chk(done === 0 && req === 0, "R6 one-cycle pulse, quiet", {30'd0, done, req}, 0);
    lsync = 1;
    @(negedge clk) lsync = 0;
    @(negedge clk);
    chk(req === 0, "R6 no fetch after end", 32'(req), 0);
  endtask

  task automatic t_hold();
    bank = 7'h7F; base = 21'h2000; pw = 11'd2; skip = 11'd0; lines = 10'd0;
    start_frame();
    fetch(21'h2000, 3, 32'hCAFEF00D, 32'hCAFEF00D);
    chk(done === 1, "R6 single-word frame done", 32'(done), 1);
  endtask

  task automatic t_wrap();
    bank = 7'h2A; base = 21'h1FFFFE; pw = 11'd4; skip = 11'd0; lines = 10'd0;
    #1 chk(end_addr === 21'h000002, "R7 end wraps", 32'(end_addr), 32'h2);
    start_frame();
    fetch(21'h1FFFFE, 0, 32'h5, 32'h5);
    chk(addr[28:22] === 7'h2A && addr[21:1] === 21'h0, "R7 wrap keeps bank", addr, baddr(7'h2A, 0));
    fetch(21'h000000, 0, 32'h6, 32'h6);
    chk(done === 1, "R7 done after wrap", 32'(done), 1);
  endtask

  task automatic t_cfg_err();
    pw = 11'd3;
    #1 chk(err === 1, "R8 odd width flagged", 32'(err), 1);
    start_frame();
    repeat (3) @(negedge clk);
    chk(req === 0, "R8 odd width no fetch", 32'(req), 0);
    pw = 11'd0;
    #1 chk(err === 1, "R8 zero width flagged", 32'(err), 1);
    start_frame();
    repeat (3) @(negedge clk);
    chk(req === 0, "R8 zero width no fetch", 32'(req), 0);
    pw = 11'd6;
    #1 chk(err === 0, "R8 even width clean", 32'(err), 0);
  endtask

  task automatic t_swap();
    bank = 7'h00; base = 21'h40; pw = 11'd8; skip = 11'd0; lines = 10'd0;
    start_frame();
    sw_h = 0; sw_b = 0; fetch(21'h40, 0, 32'h11223344, 32'h11223344);
    sw_h = 1; sw_b = 0; fetch(21'h42, 0, 32'h11223344, 32'h33441122);
    sw_h = 0; sw_b = 1; fetch(21'h44, 0, 32'h11223344, 32'h22114433);
    sw_h = 1; sw_b = 1; fetch(21'h46, 0, 32'h11223344, 32'h44332211);
    sw_h = 0; sw_b = 0;
    chk(done === 1, "R9 frame end after swaps", 32'(done), 1);
  endtask

  task automatic t_restart();
    bank = 7'h11; base = 21'h300; pw = 11'd8; skip = 11'd2; lines = 10'd3;
    start_frame();
    fetch(21'h300, 0, 32'h7, 32'h7);
    start_frame();
    fetch(21'h300, 0, 32'h8, 32'h8);
    chk(addr === baddr(7'h11, 21'h302), "R10 restart continues", addr, baddr(7'h11, 21'h302));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_lines();
    t_hold();
    t_wrap();
    t_cfg_err();
    t_swap();
    t_restart();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule